// File: doc/BRIEF.md
# x86-64 Instruction Length and Prefix Decoder

This block sits at the front of an instruction inspection path. Raw 64-bit-mode machine code arrives one byte at a time over a valid/ready handshake. The decoder works out where each instruction ends using only the bytes themselves, since the stream has no separators. When the last byte of an instruction is accepted, it produces one record on a second valid/ready interface.

The record gives the byte count and the legacy modifier prefixes seen. It also gives the REX nibble, the opcode map and opcode byte, and any mandatory prefix absorbed into the opcode identity. Finally it carries the ModR/M fields, whether a SIB byte was present, and the displacement size. Only a small fixed opcode table is recognised. An opcode outside the table closes the instruction at once with an unknown flag. A run that would go past the architectural 15-byte limit is closed with a length error. Decoding then restarts on the very next byte.

Top module: `xld_decoder`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a record is held and `rec_ready` is low. A held record keeps all its fields unchanged until it is taken. With `rec_ready` held high the decoder takes one byte every cycle.
- R2: Before the opcode, legacy prefixes are consumed, and the last one of each kind wins. F0 sets `rec_lock`. F3 gives `rec_rep`=1 and F2 gives `rec_rep`=2. 66 sets `rec_opsz` and 67 sets `rec_adsz`. The segment override bytes 26, 2E, 36, 3E, 64 and 65 give `rec_seg` values 1 to 6 respectively, and 0 means none.
- R3: A byte in 40..4F seen in prefix position is a REX byte. It sets `rec_rex_vld`, and its low nibble appears on `rec_rex` (bit 3 W, bit 2 R, bit 1 X, bit 0 B). The next byte is always taken as the opcode.
- R4: In opcode position a 0F byte is an escape giving `rec_map`=1. If the byte after it is 38 the map is 2, and if it is 3A the map is 3, with the following byte being the opcode. A plain one-byte opcode has map 0. `rec_opcode` is the opcode byte itself.
- R5: On a 0F escape, the most recent of 66, F3 and F2 becomes the mandatory prefix: `rec_mand` is 1 for 66, 2 for F3 and 3 for F2, and 0 if none was seen. That prefix's modifier flag (`rec_opsz` or `rec_rep`) is cleared.
- R6: Known opcodes are, in map 0, 90 and C3 without ModR/M and 89 and 31 with ModR/M. In map 1 they are 28, 54, 58, 59 and E6, all with ModR/M.
- R7: The ModR/M byte gives `rec_mod`=bits 7:6 and `rec_rm`=bits 2:0. `rec_reg` is REX.R followed by bits 5:3.
- R8: A SIB byte follows exactly when mod is not 3 and r/m is 4. It sets `rec_has_sib` and adds one byte to the length.
- R9: The displacement size `rec_disp` follows mod and r/m. Mod 1 gives 1 byte and mod 2 gives 4 bytes. Mod 0 gives 4 bytes when r/m is 5, or when a SIB byte is present and its base field (bits 2:0) is 5. Every other case gives 0.
- R10: `rec_len` counts every byte of the instruction. For example, 48 89 E5 is 3 bytes and 0F 28 04 25 00 20 40 00 is 8 bytes.
- R11: An opcode byte not in the table ends the instruction at that byte. The record has `rec_unknown` set, no ModR/M and no SIB, and a length equal to the bytes taken so far (1 when nothing preceded it). The next byte starts a new instruction.
- R12: If the 15th byte does not complete the instruction, a record with `rec_toolong` set and length 15 is produced. The next byte starts a new instruction. An instruction of exactly 15 bytes is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_byte | input | 8 | Machine-code byte |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_len | output | 4 | Instruction length in bytes |
| rec_lock | output | 1 | Lock prefix seen |
| rec_rep | output | 2 | Repeat modifier: 0 none, 1 F3, 2 F2 |
| rec_seg | output | 3 | Segment override code, 0 none |
| rec_opsz | output | 1 | Operand-size override as modifier |
| rec_adsz | output | 1 | Address-size override |
| rec_mand | output | 2 | Mandatory prefix: 0 none, 1 66, 2 F3, 3 F2 |
| rec_rex_vld | output | 1 | REX byte present |
| rec_rex | output | 4 | REX W, R, X, B bits |
| rec_map | output | 2 | Opcode map: 0 one-byte, 1 0F, 2 0F38, 3 0F3A |
| rec_opcode | output | 8 | Opcode byte |
| rec_has_modrm | output | 1 | ModR/M byte present |
| rec_has_sib | output | 1 | SIB byte present |
| rec_mod | output | 2 | ModR/M mod field |
| rec_reg | output | 4 | ModR/M reg field extended by REX.R |
| rec_rm | output | 3 | ModR/M r/m field |
| rec_disp | output | 3 | Displacement bytes: 0, 1 or 4 |
| rec_unknown | output | 1 | Opcode not in table |
| rec_toolong | output | 1 | Length limit exceeded |

## Verification
Some properties are checked on every cycle. A held record must stay frozen and back-pressure must reach the byte input. Every emitted record must keep its ModR/M, SIB and displacement fields consistent with one another. Unknown and over-length records must carry their fixed shapes, and a mandatory prefix may only appear with an escaped map. Other behaviour only the bench scenarios can show: that lengths are right for concrete byte runs, that the last prefix of a kind wins, and that REX.R reaches the reg field. The scenarios also cover recovery after an unknown opcode or an over-length run, and the 15-byte boundary case. They run with the consumer both always ready and stalling irregularly.

// File: rtl/xld_pkg.sv
package xld_pkg;

    typedef enum logic [2:0] {
        ST_PFX   = 3'd0,
        ST_OPC   = 3'd1,
        ST_ESC   = 3'd2,
        ST_ESC3  = 3'd3,
        ST_MODRM = 3'd4,
        ST_SIB   = 3'd5,
        ST_DISP  = 3'd6
    } st_e;

    typedef enum logic [1:0] {
        MAP_1B   = 2'd0,
        MAP_0F   = 2'd1,
        MAP_0F38 = 2'd2,
        MAP_0F3A = 2'd3
    } map_e;

    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_LOCK  = 3'd1,
        PK_REP   = 3'd2,
        PK_REPNE = 3'd3,
        PK_SEG   = 3'd4,
        PK_OPSZ  = 3'd5,
        PK_ADSZ  = 3'd6
    } pfx_kind_e;

    localparam logic [1:0] REP_F3  = 2'd1;
    localparam logic [1:0] REP_F2  = 2'd2;
    localparam logic [1:0] MAND_66 = 2'd1;
    localparam logic [1:0] MAND_F3 = 2'd2;
    localparam logic [1:0] MAND_F2 = 2'd3;

    typedef struct packed {
        logic       lock;
        logic [1:0] rep;
        logic [2:0] seg;
        logic       opsz;
        logic       adsz;
        logic [1:0] mand;
        logic       rex_vld;
        logic [3:0] rex;
        map_e       map;
        logic [7:0] opc;
        logic       has_modrm;
        logic       has_sib;
        logic [1:0] mod_f;
        logic [3:0] reg_f;
        logic [2:0] rm_f;
        logic [2:0] disp;
        logic       unknown;
        logic       toolong;
    } rec_t;

endpackage

// File: rtl/xld_byte_class.sv
module xld_byte_class
    import xld_pkg::*;
(
    input  logic [7:0] byte_i,
    output pfx_kind_e  kind_o,
    output logic [2:0] seg_o,
    output logic       is_rex_o,
    output logic       is_esc_o
);
    always_comb begin
        kind_o = PK_NONE;
        seg_o  = 3'd0;
        case (byte_i)
            8'hF0: kind_o = PK_LOCK;
            8'hF3: kind_o = PK_REP;
            8'hF2: kind_o = PK_REPNE;
            8'h66: kind_o = PK_OPSZ;
            8'h67: kind_o = PK_ADSZ;
            8'h26: begin kind_o = PK_SEG; seg_o = 3'd1; end
            8'h2E: begin kind_o = PK_SEG; seg_o = 3'd2; end
            8'h36: begin kind_o = PK_SEG; seg_o = 3'd3; end
            8'h3E: begin kind_o = PK_SEG; seg_o = 3'd4; end
            8'h64: begin kind_o = PK_SEG; seg_o = 3'd5; end
            8'h65: begin kind_o = PK_SEG; seg_o = 3'd6; end
            default: ;
        endcase
    end

    assign is_rex_o = (byte_i[7:4] == 4'h4);
    assign is_esc_o = (byte_i == 8'h0F);
endmodule

// File: rtl/xld_op_table.sv
module xld_op_table
    import xld_pkg::*;
(
    input  map_e       map_i,
    input  logic [7:0] opc_i,
    output logic       known_o,
    output logic       modrm_o
);
    localparam int N_OPS = 9;
    localparam int ENT_W = 11;
    // entry: {map[1:0], opcode[7:0], needs_modrm}
    localparam logic [N_OPS*ENT_W-1:0] TAB = {
        {2'd0, 8'h90, 1'b0},
        {2'd0, 8'hC3, 1'b0},
        {2'd0, 8'h89, 1'b1},
        {2'd0, 8'h31, 1'b1},
        {2'd1, 8'h28, 1'b1},
        {2'd1, 8'h54, 1'b1},
        {2'd1, 8'h58, 1'b1},
        {2'd1, 8'h59, 1'b1},
        {2'd1, 8'hE6, 1'b1}
    };

    logic [N_OPS-1:0] hit;
    logic [N_OPS-1:0] mrm;

    for (genvar i = 0; i < N_OPS; i++) begin : g_ent
        localparam logic [ENT_W-1:0] ENT = TAB[i*ENT_W +: ENT_W];
        assign hit[i] = (2'(map_i) == ENT[10:9]) && (opc_i == ENT[8:1]);
        assign mrm[i] = hit[i] & ENT[0];
    end

    assign known_o = |hit;
    assign modrm_o = |mrm;
endmodule

// File: rtl/xld_ea_len.sv
module xld_ea_len (
    input  logic       sib_stage_i,
    input  logic [1:0] mod_i,
    input  logic [2:0] low3_i,
    output logic       need_sib_o,
    output logic [2:0] disp_o
);
    // low3_i is r/m on the ModR/M byte and the base field on the SIB byte
    always_comb begin
        need_sib_o = !sib_stage_i && (mod_i != 2'd3) && (low3_i == 3'd4);
        case (mod_i)
            2'd1:    disp_o = 3'd1;
            2'd2:    disp_o = 3'd4;
            2'd0:    disp_o = (low3_i == 3'd5) ? 3'd4 : 3'd0;
            default: disp_o = 3'd0;
        endcase
    end
endmodule

// File: rtl/xld_decoder.sv
module xld_decoder
    import xld_pkg::*;
#(
    parameter  int MAX_LEN = 15,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [LEN_W-1:0] rec_len,
    output logic             rec_lock,
    output logic [1:0]       rec_rep,
    output logic [2:0]       rec_seg,
    output logic             rec_opsz,
    output logic             rec_adsz,
    output logic [1:0]       rec_mand,
    output logic             rec_rex_vld,
    output logic [3:0]       rec_rex,
    output logic [1:0]       rec_map,
    output logic [7:0]       rec_opcode,
    output logic             rec_has_modrm,
    output logic             rec_has_sib,
    output logic [1:0]       rec_mod,
    output logic [3:0]       rec_reg,
    output logic [2:0]       rec_rm,
    output logic [2:0]       rec_disp,
    output logic             rec_unknown,
    output logic             rec_toolong
);
    typedef struct packed {
        st_e              st;
        logic [LEN_W-1:0] cnt;
        logic [1:0]       mand_cand;
        logic [2:0]       disp_left;
        rec_t             cur;
        logic             out_vld;
        logic [LEN_W-1:0] out_len;
        rec_t             out;
    } state_t;

    state_t q, d;

    pfx_kind_e  pk;
    logic [2:0] seg_code;
    logic       is_rex, is_esc;
    map_e       map_sel;
    logic       op_known, op_mrm;
    logic       ea_sib_stage, ea_need_sib;
    logic [1:0] ea_mod;
    logic [2:0] ea_disp;
    logic       accept;

    xld_byte_class u_class (
        .byte_i  (in_byte),
        .kind_o  (pk),
        .seg_o   (seg_code),
        .is_rex_o(is_rex),
        .is_esc_o(is_esc)
    );

    always_comb begin
        case (q.st)
            ST_ESC:  map_sel = MAP_0F;
            ST_ESC3: map_sel = q.cur.map;
            default: map_sel = MAP_1B;
        endcase
    end

    xld_op_table u_table (
        .map_i  (map_sel),
        .opc_i  (in_byte),
        .known_o(op_known),
        .modrm_o(op_mrm)
    );

    assign ea_sib_stage = (q.st == ST_SIB);
    assign ea_mod       = ea_sib_stage ? q.cur.mod_f : in_byte[7:6];

    xld_ea_len u_ea (
        .sib_stage_i(ea_sib_stage),
        .mod_i      (ea_mod),
        .low3_i     (in_byte[2:0]),
        .need_sib_o (ea_need_sib),
        .disp_o     (ea_disp)
    );

    assign in_ready = !q.out_vld || rec_ready;
    assign accept   = in_valid && in_ready;

    rec_t             rec_n;
    logic             done, take_opc, go_esc;
    logic [LEN_W-1:0] nc;

    always_comb begin
        d        = q;
        rec_n    = q.cur;
        done     = 1'b0;
        take_opc = 1'b0;
        go_esc   = 1'b0;
        nc       = q.cnt + LEN_W'(1);

        if (q.out_vld && rec_ready) d.out_vld = 1'b0;

        if (accept) begin
            case (q.st)
                ST_PFX: begin
                    if (pk != PK_NONE) begin
                        case (pk)
                            PK_LOCK:  rec_n.lock = 1'b1;
                            PK_REP:   begin rec_n.rep = REP_F3; d.mand_cand = MAND_F3; end
                            PK_REPNE: begin rec_n.rep = REP_F2; d.mand_cand = MAND_F2; end
                            PK_SEG:   rec_n.seg = seg_code;
                            PK_OPSZ:  begin rec_n.opsz = 1'b1; d.mand_cand = MAND_66; end
                            PK_ADSZ:  rec_n.adsz = 1'b1;
                            default: ;
                        endcase
                    end else if (is_rex) begin
                        rec_n.rex_vld = 1'b1;
                        rec_n.rex     = in_byte[3:0];
                        d.st          = ST_OPC;
                    end else if (is_esc) begin
                        go_esc = 1'b1;
                    end else begin
                        take_opc = 1'b1;
                    end
                end
                ST_OPC: begin
                    if (is_esc) go_esc = 1'b1;
                    else        take_opc = 1'b1;
                end
                ST_ESC: begin
                    if (in_byte == 8'h38) begin
                        rec_n.map = MAP_0F38;
                        d.st      = ST_ESC3;
                    end else if (in_byte == 8'h3A) begin
                        rec_n.map = MAP_0F3A;
                        d.st      = ST_ESC3;
                    end else begin
                        take_opc = 1'b1;
                    end
                end
                ST_ESC3: take_opc = 1'b1;
                ST_MODRM: begin
                    rec_n.has_modrm = 1'b1;
                    rec_n.mod_f     = in_byte[7:6];
                    rec_n.reg_f     = {q.cur.rex[2], in_byte[5:3]};
                    rec_n.rm_f      = in_byte[2:0];
                    if (ea_need_sib) begin
                        d.st = ST_SIB;
                    end else if (ea_disp != 3'd0) begin
                        rec_n.disp  = ea_disp;
                        d.disp_left = ea_disp;
                        d.st        = ST_DISP;
                    end else begin
                        done = 1'b1;
                    end
                end
                ST_SIB: begin
                    rec_n.has_sib = 1'b1;
                    rec_n.disp    = ea_disp;
                    if (ea_disp != 3'd0) begin
                        d.disp_left = ea_disp;
                        d.st        = ST_DISP;
                    end else begin
                        done = 1'b1;
                    end
                end
                ST_DISP: begin
                    if (q.disp_left == 3'd1) done = 1'b1;
                    else d.disp_left = q.disp_left - 3'd1;
                end
                default: ;
            endcase

            if (go_esc) begin
                rec_n.mand = q.mand_cand;
                if (q.mand_cand == MAND_66) rec_n.opsz = 1'b0;
                if (q.mand_cand == MAND_F3 || q.mand_cand == MAND_F2) rec_n.rep = 2'd0;
                rec_n.map = MAP_0F;
                d.st      = ST_ESC;
            end

            if (take_opc) begin
                rec_n.map = map_sel;
                rec_n.opc = in_byte;
                if (!op_known) begin
                    rec_n.unknown = 1'b1;
                    done          = 1'b1;
                end else if (!op_mrm) begin
                    done = 1'b1;
                end else begin
                    d.st = ST_MODRM;
                end
            end

            if (done || nc == LEN_W'(MAX_LEN)) begin
                d.out_vld     = 1'b1;
                d.out         = rec_n;
                d.out.toolong = !done;
                d.out_len     = nc;
                d.st          = ST_PFX;
                d.cnt         = '0;
                d.mand_cand   = 2'd0;
                d.disp_left   = 3'd0;
                d.cur         = '0;
            end else begin
                d.cur = rec_n;
                d.cnt = nc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rec_valid     = q.out_vld;
    assign rec_len       = q.out_len;
    assign rec_lock      = q.out.lock;
    assign rec_rep       = q.out.rep;
    assign rec_seg       = q.out.seg;
    assign rec_opsz      = q.out.opsz;
    assign rec_adsz      = q.out.adsz;
    assign rec_mand      = q.out.mand;
    assign rec_rex_vld   = q.out.rex_vld;
    assign rec_rex       = q.out.rex;
    assign rec_map       = q.out.map;
    assign rec_opcode    = q.out.opc;
    assign rec_has_modrm = q.out.has_modrm;
    assign rec_has_sib   = q.out.has_sib;
    assign rec_mod       = q.out.mod_f;
    assign rec_reg       = q.out.reg_f;
    assign rec_rm        = q.out.rm_f;
    assign rec_disp      = q.out.disp;
    assign rec_unknown   = q.out.unknown;
    assign rec_toolong   = q.out.toolong;
endmodule

// File: rtl/xld_decoder_chk.sv
module xld_decoder_chk #(
    parameter  int MAX_LEN = 15,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [LEN_W-1:0] rec_len,
    input logic [1:0]       rec_mand,
    input logic [1:0]       rec_map,
    input logic [7:0]       rec_opcode,
    input logic             rec_has_modrm,
    input logic             rec_has_sib,
    input logic [1:0]       rec_mod,
    input logic [3:0]       rec_reg,
    input logic [2:0]       rec_rm,
    input logic [2:0]       rec_disp,
    input logic             rec_unknown,
    input logic             rec_toolong
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid &&
            $stable({rec_len, rec_mand, rec_map, rec_opcode, rec_has_modrm, rec_has_sib,
                     rec_mod, rec_reg, rec_rm, rec_disp, rec_unknown, rec_toolong}));

    assert_backpressure_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |-> !in_ready);

    assert_mand_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_mand != 2'd0 |-> rec_map != 2'd0);

    assert_sib_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_has_sib |-> rec_has_modrm && rec_mod != 2'd3 && rec_rm == 3'd4);

    assert_disp8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_has_modrm && !rec_toolong && rec_mod == 2'd1 |-> rec_disp == 3'd1);

    assert_regdirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_has_modrm && rec_mod == 2'd3 |-> rec_disp == 3'd0 && !rec_has_sib);

    assert_len_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_len != '0 && rec_len <= LEN_W'(MAX_LEN));

    assert_unknown_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_unknown |-> !rec_has_modrm && !rec_has_sib && rec_disp == 3'd0);

    assert_toolong_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_toolong |-> rec_len == LEN_W'(MAX_LEN) && $onehot0({rec_unknown, rec_toolong}));
endmodule

bind xld_decoder xld_decoder_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_len      (rec_len),
    .rec_mand     (rec_mand),
    .rec_map      (rec_map),
    .rec_opcode   (rec_opcode),
    .rec_has_modrm(rec_has_modrm),
    .rec_has_sib  (rec_has_sib),
    .rec_mod      (rec_mod),
    .rec_reg      (rec_reg),
    .rec_rm       (rec_rm),
    .rec_disp     (rec_disp),
    .rec_unknown  (rec_unknown),
    .rec_toolong  (rec_toolong)
);

// File: tb/xld_decoder_bench.sv
module xld_decoder_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, in_valid, in_ready, rec_valid, rec_ready;
    logic [7:0] in_byte;
    logic [3:0] rec_len, rec_rex, rec_reg;
    logic       rec_lock, rec_opsz, rec_adsz, rec_rex_vld, rec_has_modrm, rec_has_sib;
    logic       rec_unknown, rec_toolong;
    logic [1:0] rec_rep, rec_mand, rec_map, rec_mod;
    logic [2:0] rec_seg, rec_rm, rec_disp;
    logic [7:0] rec_opcode;

    xld_decoder u_xld_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_len(rec_len), .rec_lock(rec_lock),
        .rec_rep(rec_rep), .rec_seg(rec_seg), .rec_opsz(rec_opsz), .rec_adsz(rec_adsz),
        .rec_mand(rec_mand), .rec_rex_vld(rec_rex_vld), .rec_rex(rec_rex), .rec_map(rec_map),
        .rec_opcode(rec_opcode), .rec_has_modrm(rec_has_modrm), .rec_has_sib(rec_has_sib),
        .rec_mod(rec_mod), .rec_reg(rec_reg), .rec_rm(rec_rm), .rec_disp(rec_disp),
        .rec_unknown(rec_unknown), .rec_toolong(rec_toolong)
    );

    typedef struct packed {
        logic [3:0] len; logic lock; logic [1:0] rep; logic [2:0] seg; logic opsz; logic adsz;
        logic [1:0] mand; logic rexv; logic [3:0] rex; logic [1:0] map; logic [7:0] opc;
        logic hm; logic hs; logic [1:0] md; logic [3:0] rg; logic [2:0] rm; logic [2:0] disp;
        logic unk; logic tl;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_bad = 0, waits = 0;
    bit    stall_mode = 1'b0, finished = 1'b0;
    logic [7:0] lf = 8'hA5;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_rec(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // consumer ready pattern
    always @(negedge clk) begin
        lf        = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        rec_ready = stall_mode ? lf[0] : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && rec_valid && rec_ready) begin
            exp_t act;
            act = {rec_len, rec_lock, rec_rep, rec_seg, rec_opsz, rec_adsz, rec_mand, rec_rex_vld,
                   rec_rex, rec_map, rec_opcode, rec_has_modrm, rec_has_sib, rec_mod, rec_reg,
                   rec_rm, rec_disp, rec_unknown, rec_toolong};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected record", 64'(act), 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, 64'(act), 64'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; rec_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!rec_valid && in_ready, "R1 reset state", 64'({rec_valid, in_ready}), 64'b01);

        // R3 R7 R10: 48 89 E5
        e = '0; e.len = 3; e.rexv = 1; e.rex = 4'h8; e.opc = 8'h89; e.hm = 1; e.md = 3; e.rg = 4; e.rm = 5;
        expect_rec(e, "R10 48 89 E5");
        // R6: 90 and C3
        e = '0; e.len = 1; e.opc = 8'h90; expect_rec(e, "R6 nop");
        e = '0; e.len = 1; e.opc = 8'hC3; expect_rec(e, "R6 ret");
        // R6: 48 31 C0
        e = '0; e.len = 3; e.rexv = 1; e.rex = 4'h8; e.opc = 8'h31; e.hm = 1; e.md = 3;
        expect_rec(e, "R6 xor");
        // R5: F3 0F E6 C9
        e = '0; e.len = 4; e.mand = 2; e.map = 1; e.opc = 8'hE6; e.hm = 1; e.md = 3; e.rg = 1; e.rm = 1;
        expect_rec(e, "R5 F3 escape");
        // R8 R9 R10: 0F 28 04 25 disp32
        e = '0; e.len = 8; e.map = 1; e.opc = 8'h28; e.hm = 1; e.rm = 4; e.hs = 1; e.disp = 4;
        expect_rec(e, "R10 eight byte sib");
        waits = 0;
        push(8'h48); push(8'h89); push(8'hE5); push(8'h90); push(8'hC3);
        push(8'h48); push(8'h31); push(8'hC0);
        push(8'hF3); push(8'h0F); push(8'hE6); push(8'hC9);
        push(8'h0F); push(8'h28); push(8'h04); push(8'h25);
        push(8'h00); push(8'h20); push(8'h40); push(8'h00);
        chk(waits == 0, "R1 one byte per cycle", 64'(waits), 64'd0);

        // R2: F0 2E 67 89 45 10
        e = '0; e.len = 6; e.lock = 1; e.seg = 2; e.adsz = 1; e.opc = 8'h89; e.hm = 1; e.md = 1; e.rm = 5; e.disp = 1;
        expect_rec(e, "R2 lock seg adsz");
        push(8'hF0); push(8'h2E); push(8'h67); push(8'h89); push(8'h45); push(8'h10);
        // R2: F2 66 31 00 (no escape, prefixes stay modifiers)
        e = '0; e.len = 4; e.rep = 2; e.opsz = 1; e.opc = 8'h31; e.hm = 1;
        expect_rec(e, "R2 repne opsz");
        push(8'hF2); push(8'h66); push(8'h31); push(8'h00);
        // R5: 66 F3 0F 58 C1, last candidate wins
        e = '0; e.len = 5; e.opsz = 1; e.mand = 2; e.map = 1; e.opc = 8'h58; e.hm = 1; e.md = 3; e.rm = 1;
        expect_rec(e, "R5 last mandatory wins");
        push(8'h66); push(8'hF3); push(8'h0F); push(8'h58); push(8'hC1);
        // R5: 66 0F 54 C8
        e = '0; e.len = 4; e.mand = 1; e.map = 1; e.opc = 8'h54; e.hm = 1; e.md = 3; e.rg = 1;
        expect_rec(e, "R5 66 mandatory");
        push(8'h66); push(8'h0F); push(8'h54); push(8'hC8);

        stall_mode = 1'b1;
        // R9: 89 05 disp32
        e = '0; e.len = 6; e.opc = 8'h89; e.hm = 1; e.rm = 5; e.disp = 4;
        expect_rec(e, "R9 mod0 rm5");
        push(8'h89); push(8'h05); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        // R9: 89 04 65 disp32 (sib base 5)
        e = '0; e.len = 7; e.opc = 8'h89; e.hm = 1; e.rm = 4; e.hs = 1; e.disp = 4;
        expect_rec(e, "R9 sib base5");
        push(8'h89); push(8'h04); push(8'h65); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        // R8: 89 04 24 (sib, no disp)
        e = '0; e.len = 3; e.opc = 8'h89; e.hm = 1; e.rm = 4; e.hs = 1;
        expect_rec(e, "R8 sib no disp");
        push(8'h89); push(8'h04); push(8'h24);
        // R8: 89 84 24 disp32
        e = '0; e.len = 7; e.opc = 8'h89; e.hm = 1; e.md = 2; e.rm = 4; e.hs = 1; e.disp = 4;
        expect_rec(e, "R8 mod2 sib");
        push(8'h89); push(8'h84); push(8'h24); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        // R3 R7: 4C 89 E5 -> reg 12
        e = '0; e.len = 3; e.rexv = 1; e.rex = 4'hC; e.opc = 8'h89; e.hm = 1; e.md = 3; e.rg = 4'hC; e.rm = 5;
        expect_rec(e, "R7 rex.r reg");
        push(8'h4C); push(8'h89); push(8'hE5);
        // R7: 44 89 4C 24 08
        e = '0; e.len = 5; e.rexv = 1; e.rex = 4'h4; e.opc = 8'h89; e.hm = 1; e.md = 1; e.rg = 9; e.rm = 4; e.hs = 1; e.disp = 1;
        expect_rec(e, "R7 sib disp8");
        push(8'h44); push(8'h89); push(8'h4C); push(8'h24); push(8'h08);
        // R11: 07, then 66 07, then 90 resync
        e = '0; e.len = 1; e.opc = 8'h07; e.unk = 1; expect_rec(e, "R11 unknown");
        e = '0; e.len = 2; e.opsz = 1; e.opc = 8'h07; e.unk = 1; expect_rec(e, "R11 unknown after prefix");
        e = '0; e.len = 1; e.opc = 8'h90; expect_rec(e, "R11 resync");
        push(8'h07); push(8'h66); push(8'h07); push(8'h90);
        // R4: 0F 38 00, 0F 3A 0F, 0F 59 C0
        e = '0; e.len = 3; e.map = 2; e.opc = 8'h00; e.unk = 1; expect_rec(e, "R4 map 0F38");
        e = '0; e.len = 3; e.map = 3; e.opc = 8'h0F; e.unk = 1; expect_rec(e, "R4 map 0F3A");
        e = '0; e.len = 3; e.map = 1; e.opc = 8'h59; e.hm = 1; e.md = 3; expect_rec(e, "R4 map 0F");
        push(8'h0F); push(8'h38); push(8'h00);
        push(8'h0F); push(8'h3A); push(8'h0F);
        push(8'h0F); push(8'h59); push(8'hC0);
        // R12: fifteen 66 bytes, then 90
        e = '0; e.len = 15; e.opsz = 1; e.tl = 1; expect_rec(e, "R12 prefix run");
        e = '0; e.len = 1; e.opc = 8'h90; expect_rec(e, "R12 resync");
        for (int i = 0; i < 15; i++) push(8'h66);
        push(8'h90);
        // R12: 11x 26, 0F 28 04 25 -> limit hit on SIB; tail re-decoded
        e = '0; e.len = 15; e.seg = 1; e.map = 1; e.opc = 8'h28; e.hm = 1; e.rm = 4; e.hs = 1; e.disp = 4; e.tl = 1;
        expect_rec(e, "R12 limit inside operand");
        e = '0; e.len = 1; e.opc = 8'h00; e.unk = 1; expect_rec(e, "R12 tail 00");
        e = '0; e.len = 1; e.opc = 8'h20; e.unk = 1; expect_rec(e, "R12 tail 20");
        e = '0; e.len = 2; e.rexv = 1; e.opc = 8'h00; e.unk = 1; expect_rec(e, "R3 tail rex");
        for (int i = 0; i < 11; i++) push(8'h26);
        push(8'h0F); push(8'h28); push(8'h04); push(8'h25);
        push(8'h00); push(8'h20); push(8'h40); push(8'h00);
        // R12: exactly 15 bytes is legal
        e = '0; e.len = 15; e.seg = 4; e.opc = 8'h89; e.hm = 1; e.rm = 4; e.hs = 1; e.disp = 4;
        expect_rec(e, "R12 fifteen legal");
        for (int i = 0; i < 8; i++) push(8'h3E);
        push(8'h89); push(8'h04); push(8'h25); push(8'h00); push(8'h20); push(8'h40); push(8'h00);
        idle();

        for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all records seen", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule